// File: doc/BRIEF.md
# Level-Coded Dual-Rail Token Link

This block moves an N-bit word across a two-phase link in which every bit travels on a pair of wires: a value wire and a phase wire. To send a token, the sender compares each new bit with the bit it sent last. If the bit is different, the value wire toggles. If the bit is the same, the phase wire toggles. For every bit, exactly one of the two wires changes per token. No wire ever returns to zero between tokens.

The receiving half takes the XOR of the two wires of each bit, which gives a per-bit parity. This parity flips with every token. The receiver accepts a token only in the cycle where the parity of every bit equals the parity it expects next. It then captures the value wires as the word, pulses a valid strobe, inverts its expected parity and toggles a single acknowledge wire. The sending half holds off any further token until it sees that acknowledge toggle.

Both halves share one clock in this model. The link wires are brought out as ports, so a neighbour can loop them back, delay them or skew them.

Top module: `dual_rail_lvl_link`

## Requirements
- R1: After reset, all value and phase wires are 0, the acknowledge output is 0, the valid strobe is 0 and the sender is ready. The first token is expected with parity 1.
- R2: In the clock cycle after a token is sent, exactly one of the two wires of every bit has toggled.
- R3: After a send, each value wire equals the corresponding bit of the sent word, so a value wire toggles exactly when its bit differs from the previous token.
- R4: A bit whose value is unchanged from the previous token toggles its phase wire.
- R5: When every bit's parity (value XOR phase) equals the expected parity, the receiver raises the valid strobe for one cycle on the next edge. In that cycle the captured word equals the value wires it accepted.
- R6: The acknowledge output toggles exactly once per accepted token and is otherwise steady.
- R7: If some bits match the expected parity and others do not, the input is incomplete. No valid strobe is raised and acknowledge does not change.
- R8: After a send, the sender reports not-ready until it observes an acknowledge toggle. A send request made while not ready is ignored and leaves every wire unchanged.
- R9: The expected parity alternates, so rails held steady after an acceptance are never accepted a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_valid | input | 1 | Request to send tx_word |
| tx_word | input | W | Word to send |
| tx_ready | output | 1 | High when no token is awaiting acknowledge |
| tx_dat | output | W | Sender value wires |
| tx_phs | output | W | Sender phase wires |
| ack_in | input | 1 | Acknowledge wire seen by the sender |
| rx_dat | input | W | Receiver value wires |
| rx_phs | input | W | Receiver phase wires |
| rx_ack | output | 1 | Receiver two-phase acknowledge |
| rx_valid | output | 1 | One-cycle strobe per accepted token |
| rx_word | output | W | Last accepted word |

## Verification
The hardest state to reach from the ports is a half-arrived token, where some bit pairs have toggled and others have not. A correct sender never produces one. The bench therefore places a selector in front of the receiver inputs. This selector replaces the looped-back rails with a copy in which only one bit's phase wire has toggled. It holds that copy for several cycles while watching the strobe and the acknowledge wire, then restores the loopback. The sequence also covers three other situations: words that keep all bits, words that flip all bits, and a send request issued during the acknowledge wait.

// File: rtl/dual_rail_lvl_link.sv
module dual_rail_lvl_link #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_word,
  output logic         tx_ready,
  output logic [W-1:0] tx_dat,
  output logic [W-1:0] tx_phs,
  input  logic         ack_in,
  input  logic [W-1:0] rx_dat,
  input  logic [W-1:0] rx_phs,
  output logic         rx_ack,
  output logic         rx_valid,
  output logic [W-1:0] rx_word
);

  logic pending, ack_seen, exp_par;
  logic fire, token_ok;

  assign tx_ready = !pending;
  assign fire     = tx_valid && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_dat   <= '0;
      tx_phs   <= '0;
      pending  <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      ack_seen <= ack_in;
      if (fire) begin
        tx_dat  <= tx_word;
        tx_phs  <= tx_phs ^ ~(tx_word ^ tx_dat);
        pending <= 1'b1;
      end else if (ack_in != ack_seen) begin
        pending <= 1'b0;
      end
    end
  end

  assign token_ok = ((rx_dat ^ rx_phs) == {W{exp_par}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_par  <= 1'b1;
      rx_ack   <= 1'b0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
    end else begin
      rx_valid <= token_ok;
      if (token_ok) begin
        exp_par <= ~exp_par;
        rx_ack  <= ~rx_ack;
        rx_word <= rx_dat;
      end
    end
  end

  // R2
  one_wire_per_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=>
      ((((tx_dat ^ $past(tx_dat)) ^ (tx_phs ^ $past(tx_phs))) == {W{1'b1}}) &&
       (((tx_dat ^ $past(tx_dat)) & (tx_phs ^ $past(tx_phs))) == '0)));

  // R3
  value_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_dat == $past(tx_word)));

  // R8
  idle_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_ready) |=> ($stable(tx_dat) && $stable(tx_phs)));

  // R6
  ack_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_ack != $past(rx_ack)));

  // R6
  ack_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_ack));

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_word == $past(rx_dat)));

endmodule

// File: tb/dual_rail_lvl_link_bench.sv
module dual_rail_lvl_link_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic tx_ready, rx_ack, rx_valid;
  logic [W-1:0] tx_dat, tx_phs, rx_dat, rx_phs, rx_word;
  logic inj = 1'b0;
  logic [W-1:0] inj_dat = '0, inj_phs = '0;

  int checks = 0, fails = 0, accepts = 0, sends = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] mdl_dat = '0, mdl_phs = '0;
  logic last_ack = 1'b0;

  always #2 clk = ~clk;

  assign rx_dat = inj ? inj_dat : tx_dat;
  assign rx_phs = inj ? inj_phs : tx_phs;

  dual_rail_lvl_link #(.W(W)) u_dual_rail_lvl_link (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_word(tx_word),
    .tx_ready(tx_ready), .tx_dat(tx_dat), .tx_phs(tx_phs), .ack_in(rx_ack),
    .rx_dat(rx_dat), .rx_phs(rx_phs), .rx_ack(rx_ack), .rx_valid(rx_valid),
    .rx_word(rx_word));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected words on every strobe
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      accepts++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected accept", rx_word, 0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(rx_word == e, "R5 word", rx_word, e);
      end
      chk(rx_ack != last_ack, "R6 ack toggle", rx_ack, ~last_ack);
    end else if (rst_n) begin
      if (rx_ack != last_ack) chk(1'b0, "R6 ack steady", rx_ack, last_ack);
    end
    last_ack = rx_ack;
  end

  task automatic send(input logic [W-1:0] w, input bit probe_busy);
    logic [W-1:0] chg;
    while (!tx_ready) @(negedge clk);
    tx_word = w;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    sends++;
    chg = w ^ mdl_dat;
    mdl_phs = mdl_phs ^ ~chg;
    mdl_dat = w;
    chk(tx_dat == mdl_dat, "R3 value wires", tx_dat, mdl_dat);
    chk(tx_phs == mdl_phs, "R4 phase wires", tx_phs, mdl_phs);
    chk(tx_ready == 1'b0, "R8 busy after send", tx_ready, 0);
    exp_q.push_back(w);
    if (probe_busy) begin
      tx_word = ~w;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk(tx_dat == mdl_dat && tx_phs == mdl_phs, "R8 ignored send", {tx_dat, tx_phs}, {mdl_dat, mdl_phs});
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_dat == 0 && tx_phs == 0, "R1 rails zero", {tx_dat, tx_phs}, 0);
    chk(rx_ack == 0 && rx_valid == 0 && tx_ready == 1, "R1 outputs", {rx_ack, rx_valid, tx_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_valid == 0, "R1 no accept on idle rails", rx_valid, 0);
    send(8'hA5, 1'b0);
    send(8'hA5, 1'b0);   // all bits unchanged: phases toggle (R4)
    send(8'h5A, 1'b1);   // all bits flip (R3), busy probe (R8)
    send(8'h5B, 1'b0);
    while (!tx_ready) @(negedge clk);
    repeat (6) @(negedge clk);   // R9: steady rails, no re-accept
    chk(accepts == sends, "R9 accept count", accepts, sends);
    // R7: only bit 0 advances
    inj_dat = tx_dat;
    inj_phs = tx_phs ^ 8'h01;
    inj = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(rx_valid == 0, "R7 partial ignored", rx_valid, 0);
    end
    inj_phs = tx_phs ^ 8'h0F;
    repeat (3) @(negedge clk);
    chk(rx_valid == 0 && accepts == sends, "R7 half token ignored", accepts, sends);
    inj = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) send(W'(i * 37 + 3), i[0]);
    send(8'hFF, 1'b0);
    send(8'h00, 1'b0);
    while (!tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(accepts == sends, "R6 one accept per token", accepts, sends);
    chk(exp_q.size() == 0, "R5 all words delivered", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule